// File: doc/BRIEF.md
# Memory Bank Decoder with I/O Page Split

This block steers each processor bus cycle to one target in a 64 KB space. Five configuration levels decide the target. Three of them come from the processor's own port: a low-ROM enable, a high-ROM enable and a character/I-O enable. The other two are the cartridge's active-low GAME and EXROM lines. From these levels and the 16-bit address, the block asserts one select. The possible targets are internal RAM, BASIC ROM, kernel ROM, character ROM, the I/O page, or one of the two external cartridge ROM windows. If the address falls in an unmapped hole, no select is asserted.

When the I/O page is chosen, a second stage names the peripheral that owns the address. The block also returns that peripheral's register offset, already folded by the peripheral's mirror period. A processor write aimed at a ROM is redirected to the RAM underneath it. The exception is the cartridge-only mode, which hides almost all internal RAM. A parameter places one register stage on every output.

Top module: `bank_decoder`

## Requirements
- R1: `region_oh` bit positions: [0] RAM, [1] BASIC ROM, [2] kernel ROM, [3] character ROM, [4] I/O, [5] low cartridge ROM, [6] high cartridge ROM. At most one bit is set for every address and configuration.
- R2: With all four levels {lo_en, hi_en, game_n, exrom_n} high:
  - BASIC ROM is at A000–BFFF.
  - Kernel ROM is at E000–FFFF.
  - D000–DFFF follows R4.
  - RAM is everywhere else.
- R3: Outside the cartridge-only mode, with key written {lo_en, hi_en, game_n, exrom_n}:
  - Kernel ROM is at E000–FFFF exactly when hi_en=1.
  - BASIC ROM is at A000–BFFF exactly when lo_en=hi_en=game_n=1.
  - High cartridge ROM is at A000–BFFF when hi_en=1 and game_n=exrom_n=0.
  - Low cartridge ROM is at 8000–9FFF when lo_en=hi_en=1 and exrom_n=0.
  - Every other address maps to RAM.
- R4: Outside the cartridge-only mode, D000–DFFF maps as follows:
  - It is RAM when lo_en=hi_en=0.
  - Otherwise it is I/O when chr_en=1.
  - With chr_en=0 it is RAM for key 1000, and character ROM in every other case.
- R5: In the cartridge-only mode (game_n=0, exrom_n=1), lo_en, hi_en and chr_en are ignored. The map is:
  - RAM at 0000–0FFF.
  - Low cartridge ROM at 8000–9FFF.
  - I/O at D000–DFFF.
  - High cartridge ROM at E000–FFFF.
  - No select anywhere else.
- R6: Outside the cartridge-only mode, a write (cpu_wr=1) to BASIC, kernel, character, low-cartridge or high-cartridge ROM selects RAM instead. Writes to I/O and RAM keep their read target.
- R7: In the cartridge-only mode, a write outside 0000–0FFF never selects RAM. A cartridge ROM write keeps its cartridge select, and a write to a hole selects nothing.
- R8: `io_dev_oh` is non-zero only while the I/O region is selected. Its bits are:
  - [0] video, D000–D3FF.
  - [1] sound, D400–D7FF.
  - [2] colour RAM, D800–DBFF.
  - [3] adapter A, DC00–DCFF.
  - [4] adapter B, DD00–DDFF.
  - [5] expansion strobe 1, DE00–DEFF.
  - [6] expansion strobe 2, DF00–DFFF.
- R9: `reg_ofs` gives the low address bits of the selected device, zero-extended: video 6 bits, sound 5, colour 10, adapters 4, expansion strobes 8. It is zero when no device is selected.
- R10: With REG_OUT=1, every output shows the decode of the inputs present at the previous rising clock edge, and all outputs are zero during reset.
- R11: With REG_OUT=0, every output follows the inputs within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the assertions |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | 1 for a write cycle |
| lo_en | input | 1 | Low ROM enable level from the processor port |
| hi_en | input | 1 | High ROM enable level from the processor port |
| chr_en | input | 1 | 1 selects I/O, 0 selects character ROM or RAM in D000–DFFF |
| game_n | input | 1 | Cartridge GAME line, active low |
| exrom_n | input | 1 | Cartridge EXROM line, active low |
| region_oh | output | 7 | One-hot region select (R1 positions) |
| io_dev_oh | output | 7 | One-hot I/O device select (R8 positions) |
| reg_ofs | output | 10 | Mirror-folded register offset |

## Verification
The combinational instance must present its results in the same cycle its inputs change. The bench drives each new input on a falling edge and compares one nanosecond later, before any rising edge can act. The registered instance receives the same stimulus, and its results are due at the first rising edge after the drive. They are compared one nanosecond past that edge while the inputs are still held. The sweep covers all 32 level combinations, both strobe values, every 4 KB region and nine offsets inside each region, so every peripheral page and mirror fold is exercised.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

  localparam int NREG  = 7;
  localparam int NDEV  = 7;
  localparam int OFS_W = 10;

  typedef enum logic [2:0] {
    RG_RAM   = 3'd0,
    RG_BASIC = 3'd1,
    RG_KERN  = 3'd2,
    RG_CHR   = 3'd3,
    RG_IO    = 3'd4,
    RG_ROML  = 3'd5,
    RG_ROMH  = 3'd6,
    RG_NONE  = 3'd7
  } region_e;

  typedef enum logic [3:0] {
    MD_RAMONLY,
    MD_STD,
    MD_NOBASIC,
    MD_DRAM,
    MD_KERNONLY,
    MD_CART8,
    MD_CARTHI,
    MD_CART16,
    MD_ULTI
  } bank_mode_e;

  localparam logic [NREG-1:0] ROM_MASK =
    (NREG'(1) << RG_BASIC) | (NREG'(1) << RG_KERN) | (NREG'(1) << RG_CHR) |
    (NREG'(1) << RG_ROML)  | (NREG'(1) << RG_ROMH);

  // key = {lo_en, hi_en, game_n, exrom_n}
  function automatic bank_mode_e classify(input logic [3:0] key);
    bank_mode_e m;
    if (key[1:0] == 2'b01) m = MD_ULTI;
    else begin
      case (key)
        4'b1111:          m = MD_STD;
        4'b1010, 4'b1011: m = MD_NOBASIC;
        4'b1000:          m = MD_DRAM;
        4'b0110, 4'b0111: m = MD_KERNONLY;
        4'b1110:          m = MD_CART8;
        4'b0100:          m = MD_CARTHI;
        4'b1100:          m = MD_CART16;
        default:          m = MD_RAMONLY;
      endcase
    end
    return m;
  endfunction

  function automatic region_e read_target(input bank_mode_e m,
                                          input logic [3:0] nib,
                                          input logic chr);
    region_e r;
    r = RG_RAM;
    if (m == MD_ULTI) begin
      case (nib)
        4'h0:       r = RG_RAM;
        4'h8, 4'h9: r = RG_ROML;
        4'hD:       r = RG_IO;
        4'hE, 4'hF: r = RG_ROMH;
        default:    r = RG_NONE;
      endcase
    end else if (m != MD_RAMONLY) begin
      case (nib)
        4'h8, 4'h9:
          if (m == MD_CART8 || m == MD_CART16) r = RG_ROML;
        4'hA, 4'hB:
          if (m == MD_STD || m == MD_CART8) r = RG_BASIC;
          else if (m == MD_CARTHI || m == MD_CART16) r = RG_ROMH;
        4'hD:
          if (chr) r = RG_IO;
          else if (m != MD_DRAM) r = RG_CHR;
        4'hE, 4'hF:
          if (m != MD_NOBASIC && m != MD_DRAM) r = RG_KERN;
        default: r = RG_RAM;
      endcase
    end
    return r;
  endfunction

  function automatic logic [NREG-1:0] to_onehot(input region_e r);
    return (r == RG_NONE) ? '0 : (NREG'(1) << r);
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     addr,
  input  logic            wr,
  input  logic            lo_en,
  input  logic            hi_en,
  input  logic            chr_en,
  input  logic            game_n,
  input  logic            exrom_n,
  output logic [NREG-1:0] region_oh,
  output logic            cart_only
);

  bank_mode_e      mode;
  region_e         rd_tgt;
  logic [NREG-1:0] rd_oh;
  logic            rom_hit;
  logic            fall_thru;

  assign mode      = classify({lo_en, hi_en, game_n, exrom_n});
  assign cart_only = (mode == MD_ULTI);
  assign rd_tgt    = read_target(mode, addr[15:12], chr_en);
  assign rd_oh     = to_onehot(rd_tgt);
  assign rom_hit   = |(rd_oh & ROM_MASK);
  assign fall_thru = wr && !cart_only && rom_hit;
  assign region_oh = fall_thru ? (NREG'(1) << RG_RAM) : rd_oh;

  p_region_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_oh));

  p_write_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cart_only && rom_hit) |-> region_oh[RG_RAM]);

  p_cart_ram_fenced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_only && addr[15:12] != 4'h0) |-> !region_oh[RG_RAM]);

  p_cart_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_only && rd_tgt == RG_NONE) |-> (region_oh == '0));

endmodule

// File: rtl/io_split.sv
module io_split
  import bank_dec_pkg::*;
#(
  parameter int VID_W = 6,
  parameter int SND_W = 5,
  parameter int COL_W = 10,
  parameter int ADP_W = 4,
  parameter int EXP_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      page_addr,
  input  logic             in_io,
  output logic [NDEV-1:0]  dev_oh,
  output logic [OFS_W-1:0] ofs
);

  function automatic logic [OFS_W-1:0] lane_mask(input int g);
    int w;
    logic [OFS_W:0] t;
    case (g)
      0:       w = VID_W;
      1:       w = SND_W;
      2:       w = COL_W;
      3, 4:    w = ADP_W;
      default: w = EXP_W;
    endcase
    t = ((OFS_W+1)'(1) << w) - (OFS_W+1)'(1);
    return t[OFS_W-1:0];
  endfunction

  logic [2:0]       dev_idx;
  logic [OFS_W-1:0] lane [NDEV];

  // first three 1 KB quarters are whole devices, last quarter splits by page
  assign dev_idx = (page_addr[11:10] != 2'b11) ? {1'b0, page_addr[11:10]}
                                               : 3'd3 + {1'b0, page_addr[9:8]};

  genvar g;
  generate
    for (g = 0; g < NDEV; g++) begin : g_dev
      assign dev_oh[g] = in_io && (dev_idx == 3'(g));
      assign lane[g]   = dev_oh[g] ? (page_addr[OFS_W-1:0] & lane_mask(g)) : '0;
    end
  endgenerate

  always_comb begin
    ofs = '0;
    for (int i = 0; i < NDEV; i++) ofs = ofs | lane[i];
  end

  p_dev_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_oh));

  p_ofs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_oh == '0) |-> (ofs == '0));

  p_vid_fold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_oh[0] |-> ((ofs >> VID_W) == '0));

  p_adp_fold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_oh[3] || dev_oh[4]) |-> ((ofs >> ADP_W) == '0));

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b0,
  parameter int VID_W   = 6,
  parameter int SND_W   = 5,
  parameter int COL_W   = 10,
  parameter int ADP_W   = 4,
  parameter int EXP_W   = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic             cpu_wr,
  input  logic             lo_en,
  input  logic             hi_en,
  input  logic             chr_en,
  input  logic             game_n,
  input  logic             exrom_n,
  output logic [NREG-1:0]  region_oh,
  output logic [NDEV-1:0]  io_dev_oh,
  output logic [OFS_W-1:0] reg_ofs
);

  logic [NREG-1:0]  region_c;
  logic [NDEV-1:0]  dev_c;
  logic [OFS_W-1:0] ofs_c;
  logic             cart_only;

  bank_map u_map (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wr(cpu_wr),
    .lo_en(lo_en), .hi_en(hi_en), .chr_en(chr_en),
    .game_n(game_n), .exrom_n(exrom_n),
    .region_oh(region_c), .cart_only(cart_only)
  );

  io_split #(.VID_W(VID_W), .SND_W(SND_W), .COL_W(COL_W),
             .ADP_W(ADP_W), .EXP_W(EXP_W)) u_io (
    .clk(clk), .rst_n(rst_n), .page_addr(cpu_addr[11:0]),
    .in_io(region_c[RG_IO]), .dev_oh(dev_c), .ofs(ofs_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          region_oh <= '0;
          io_dev_oh <= '0;
          reg_ofs   <= '0;
        end else begin
          region_oh <= region_c;
          io_dev_oh <= dev_c;
          reg_ofs   <= ofs_c;
        end
      end

      p_reg_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (region_oh == $past(region_c) && io_dev_oh == $past(dev_c)));
    end else begin : g_comb
      assign region_oh = region_c;
      assign io_dev_oh = dev_c;
      assign reg_ofs   = ofs_c;
    end
  endgenerate

  p_dev_in_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_c) |-> (region_c[RG_IO] && cpu_addr[15:12] == 4'hD));

  p_cart_ignores_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_only && cpu_addr[15:12] == 4'hD) |-> region_c[RG_IO]);

endmodule

// File: tb/sim_bank_decoder.sv
module sim_bank_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        lo_en = 1'b1, hi_en = 1'b1, chr_en = 1'b1, game_n = 1'b1, exrom_n = 1'b1;
  logic [6:0]  reg0, dev0, reg1, dev1;
  logic [9:0]  ofs0, ofs1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_decoder #(.REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .lo_en(lo_en), .hi_en(hi_en), .chr_en(chr_en), .game_n(game_n), .exrom_n(exrom_n),
    .region_oh(reg0), .io_dev_oh(dev0), .reg_ofs(ofs0));

  bank_decoder #(.REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .lo_en(lo_en), .hi_en(hi_en), .chr_en(chr_en), .game_n(game_n), .exrom_n(exrom_n),
    .region_oh(reg1), .io_dev_oh(dev1), .reg_ofs(ofs1));

  function automatic logic [11:0] pick_ofs(input int i);
    case (i)
      0: return 12'h000; 1: return 12'h041; 2: return 12'h3FF;
      3: return 12'h425; 4: return 12'h8AB; 5: return 12'hC1F;
      6: return 12'hD3C; 7: return 12'hEFF; default: return 12'hF80;
    endcase
  endfunction

  // region bits: 0 RAM 1 BASIC 2 KERN 3 CHR 4 IO 5 ROML 6 ROMH
  function automatic logic [6:0] exp_region(input logic lo, hi, chr, g, ex, wr,
                                            input logic [15:0] a);
    int n = int'(a[15:12]);
    int r = 0;
    if (!g && ex) begin
      if (n == 0) r = 0;
      else if (n == 8 || n == 9) r = 5;
      else if (n == 13) r = 4;
      else if (n >= 14) r = 6;
      else r = -1;
      return (r < 0) ? 7'd0 : 7'(1 << r);
    end
    if (n == 10 || n == 11) r = (lo && hi && g) ? 1 : ((hi && !g && !ex) ? 6 : 0);
    else if (n == 8 || n == 9) r = (lo && hi && !ex) ? 5 : 0;
    else if (n >= 14) r = hi ? 2 : 0;
    else if (n == 13) begin
      if (!lo && !hi) r = 0;
      else if (chr) r = 4;
      else if (lo && !hi && !g && !ex) r = 0;
      else r = 3;
    end
    if (wr && r != 4) r = 0;
    return 7'(1 << r);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h cfg=%b%b%b%b%b wr=%b actual=%h expected=%h",
               tag, cpu_addr, lo_en, hi_en, chr_en, game_n, exrom_n, cpu_wr, act, exp);
    end
  endtask

  initial begin
    logic [6:0] er, ed;
    logic [9:0] eo;
    string tag;
    // R10: registered outputs held at zero during reset
    repeat (3) @(negedge clk);
    check("R10 reset region", int'(reg1), 0);
    check("R10 reset dev", int'(dev1), 0);
    check("R10 reset ofs", int'(ofs1), 0);
    rst_n = 1'b1;

    // R11: a change between edges appears without any clock edge
    @(posedge clk); #1;
    cpu_addr = 16'hA123; {lo_en, hi_en, chr_en, game_n, exrom_n} = 5'b11111; cpu_wr = 1'b0;
    #1 check("R11 same-cycle", int'(reg0), 2);

    for (int c = 0; c < 32; c++) begin
      for (int w = 0; w < 2; w++) begin
        for (int n = 0; n < 16; n++) begin
          for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            {lo_en, hi_en, chr_en, game_n, exrom_n} = 5'(c);
            cpu_wr = w[0];
            cpu_addr = {4'(n), pick_ofs(k)};
            er = exp_region(lo_en, hi_en, chr_en, game_n, exrom_n, cpu_wr, cpu_addr);
            ed = '0; eo = '0;
            if (er[4]) begin
              if (cpu_addr[11:10] == 2'd0)      begin ed = 7'd1;  eo = 10'(cpu_addr % 64); end
              else if (cpu_addr[11:10] == 2'd1) begin ed = 7'd2;  eo = 10'(cpu_addr % 32); end
              else if (cpu_addr[11:10] == 2'd2) begin ed = 7'd4;  eo = 10'(cpu_addr % 1024); end
              else begin
                ed = 7'(8 << cpu_addr[9:8]);
                eo = (cpu_addr[9:8] < 2) ? 10'(cpu_addr % 16) : 10'(cpu_addr % 256);
              end
            end
            if (!game_n && exrom_n) tag = cpu_wr ? "R7" : "R5";
            else if (n == 13) tag = "R4";
            else if (cpu_wr) tag = "R6";
            else if (c == 5'b11011) tag = "R2";
            else tag = "R3";
            #1;
            check("R1 onehot", ($countones(reg0) <= 1) ? 1 : 0, 1);
            check(tag, int'(reg0), int'(er));
            check("R8 device", int'(dev0), int'(ed));
            check("R9 offset", int'(ofs0), int'(eo));
            @(posedge clk); #1;
            check("R10 registered", int'({reg1, dev1, ofs1}), int'({er, ed, eo}));
          end
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule